// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Monitor

This block watches a synchronised copy of the SMBus clock line and decides when the bus has been held low too long. It keeps three separate time budgets. The first is one unbroken low period of the clock, whoever is holding it. The second is the total time this node has stretched the clock while acting as master within one message. The third is the same total while acting as slave. Every budget is a parameter counted in clock cycles. The defaults assume a 1 MHz clock: 25 ms unbroken low, 10 ms master stretch and 25 ms slave stretch. A testbench can shrink them to a few cycles.

When a budget runs out, the block sets a sticky timeout flag and sends a one-cycle action request to the bus engine. In slave role the request tells the engine to abandon the transfer and release both bus lines. In master role it tells the engine to drive a STOP condition. Software clears the flag by writing 0 to it. While the peripheral enable is low, the flag, the requests and all running counts are held at zero. The cumulative budgets restart whenever a START or STOP condition is reported.

Top module: `smbus_tlow_monitor`

## Requirements
- R1: With enable=1, the flag reads 1 one clock after the edge that samples the TLOW_CYC-th consecutive low on `scl_in`. If `scl_in` returns high after only TLOW_CYC-1 low samples, the flag stays 0.
- R2: Any high sample on `scl_in` restarts the unbroken-low count from zero. Two low runs that are each shorter than TLOW_CYC never set the flag, however long their sum.
- R3: In master role (`role_master`=1), each cycle with `stretch_active`=1 adds to the master stretch total. The flag sets once that total exceeds MEXT_CYC (MEXT_CYC+1 cycles), not when it only reaches MEXT_CYC.
- R4: In slave role (`role_master`=0), each cycle with `stretch_active`=1 adds to the slave stretch total. The flag sets once that total exceeds SEXT_CYC.
- R5: A one-cycle pulse on `start_det` or on `stop_det` clears both stretch totals. Stretch cycles counted in one role never count toward the other role's total.
- R6: In master role, each limit-reach event produces exactly one one-cycle pulse on `master_stop_req`, in the cycle the flag rises when the flag was clear. `slave_reset_req` stays 0.
- R7: In slave role, each limit-reach event produces exactly one one-cycle pulse on `slave_reset_req`, in the cycle the flag rises when the flag was clear. `master_stop_req` stays 0.
- R8: A write (`flag_wr_en`=1) with `flag_wr_data`=0 clears the flag. A write with `flag_wr_data`=1 leaves it unchanged. If a limit is reached in the same cycle as a clearing write, the flag is set.
- R9: While `enable`=0, the flag and both requests are 0 and all three counts are held at zero. After enable returns, the counts start again from zero.
- R10: Each count stops at its limit while its condition persists. A flag cleared while the condition still holds is not set again until that count has been restarted (R2, R5, R9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Peripheral enable; 0 holds flag, requests and counts cleared |
| scl_in | input | 1 | Synchronised SCL level (1 = high) |
| role_master | input | 1 | 1 = node is bus master, 0 = node is slave |
| stretch_active | input | 1 | 1 while this node itself holds SCL low |
| start_det | input | 1 | One-cycle pulse on a START condition |
| stop_det | input | 1 | One-cycle pulse on a STOP condition |
| flag_wr_en | input | 1 | Software write strobe for the timeout flag |
| flag_wr_data | input | 1 | Written flag value; 0 clears, 1 has no effect |
| timeout_flag | output | 1 | Sticky timeout/clock-low error flag |
| slave_reset_req | output | 1 | One-cycle request: reset transfer, release SDA and SCL |
| master_stop_req | output | 1 | One-cycle request: generate a STOP condition |

## Verification
Some rules are checked by assertions on every cycle. They cover the coupling between flag and requests: a request only appears with the flag set and matches the role of the previous cycle, and the two requests never coincide. They also cover the clearing effect of a high clock sample, of START/STOP, and of enable=0. The flag must stay set unless a clearing write or disable arrives, the counts must stay at their limit, and each limit-reach pulse must last one cycle.

The exact thresholds can only be shown by the bench's sweeps. These include the off-by-one between "reaches" for the unbroken low and "exceeds" for the stretch budgets. They also include the summing of split stretch periods, the independence of the two roles, the winner when a set and a clear arrive in the same cycle, and the absence of a repeat trigger after a clear.

// File: rtl/smbus_tlow_pkg.sv
// Package: shared definitions for the SMBus clock-low timeout monitor.
// Assumes: three limits, indexed by limit_e; counter widths derive from limits.
package smbus_tlow_pkg;

    // Which time budget a counter tracks.
    typedef enum logic [1:0] {
        LIM_CONT = 2'd0,   // unbroken SCL low
        LIM_MEXT = 2'd1,   // cumulative master stretch
        LIM_SEXT = 2'd2    // cumulative slave stretch
    } limit_e;

    localparam int unsigned NUM_LIMITS = 3;

    // Bits needed to hold the values 0..lim inclusive.
    function automatic int unsigned cnt_width(input int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/tlow_sat_counter.sv
// Module: saturating cycle counter with a single-shot reach pulse.
// Counts cycles with inc=1 until it holds LIMIT, then stays there.
// reached is a one-cycle pulse, registered, in the cycle after the
// edge at which the count became LIMIT. clr has priority over inc.
// Assumes: LIMIT >= 1, WIDTH can hold LIMIT.
module tlow_sat_counter #(
    parameter int unsigned LIMIT = 4,
    parameter int unsigned WIDTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic reached,
    output logic at_limit
);

    localparam logic [WIDTH-1:0] LIM_V  = WIDTH'(LIMIT);
    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LIMIT - 1);

    logic [WIDTH-1:0] cnt;
    logic             step;

    // Purpose: decide whether this cycle advances the count.
    always_comb begin
        step = inc && (cnt != LIM_V);
    end

    // Purpose: count, saturate at LIMIT and flag the arrival once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            reached <= 1'b0;
        end else if (clr) begin
            cnt     <= '0;
            reached <= 1'b0;
        end else begin
            reached <= step && (cnt == LAST_V);
            if (step) begin
                cnt <= cnt + WIDTH'(1);
            end
        end
    end

    // Purpose: expose saturation for the parent and the checker.
    always_comb begin
        at_limit = (cnt == LIM_V);
    end

endmodule

// File: rtl/tlow_flag_ctrl.sv
// Module: sticky timeout flag and role-dependent action requests.
// A hit (any counter reaching its limit) sets the flag and pulses one
// request selected by the current role. A software write of 0 clears
// the flag unless a hit arrives in the same cycle. enable=0 forces all
// outputs low.
// Assumes: hit is already a single-cycle pulse per event.
module tlow_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic role_master,
    input  logic hit,
    input  logic wr_en,
    input  logic wr_data,
    output logic flag,
    output logic stop_req,
    output logic reset_req
);

    logic wr_clear;

    // Purpose: decode a clearing write (write-1 is ignored).
    always_comb begin
        wr_clear = wr_en && !wr_data;
    end

    // Purpose: hold the sticky flag; set beats clear, disable beats both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (!enable) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (wr_clear) begin
            flag <= 1'b0;
        end
    end

    // Purpose: pulse the recovery action that matches the role.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_req  <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            stop_req  <= enable && hit && role_master;
            reset_req <= enable && hit && !role_master;
        end
    end

endmodule

// File: rtl/smbus_tlow_monitor.sv
// Module: SMBus clock-low timeout monitor (top).
// Runs three saturating counters: unbroken SCL low, master stretch total
// and slave stretch total. Any counter reaching its limit sets the
// timeout flag and requests a STOP (master) or a transfer reset (slave).
// Assumes: scl_in is already synchronised; start_det/stop_det and
// stretch_active come from the bus engine in the same clock domain.
module smbus_tlow_monitor #(
    parameter int unsigned TLOW_CYC = 25000,  // unbroken low limit
    parameter int unsigned MEXT_CYC = 10000,  // master stretch budget
    parameter int unsigned SEXT_CYC = 25000   // slave stretch budget
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_in,
    input  logic role_master,
    input  logic stretch_active,
    input  logic start_det,
    input  logic stop_det,
    input  logic flag_wr_en,
    input  logic flag_wr_data,
    output logic timeout_flag,
    output logic slave_reset_req,
    output logic master_stop_req
);
    import smbus_tlow_pkg::*;

    localparam int IDX_CONT = int'(LIM_CONT);
    localparam int IDX_MEXT = int'(LIM_MEXT);
    localparam int IDX_SEXT = int'(LIM_SEXT);

    logic [NUM_LIMITS-1:0] lim_inc;
    logic [NUM_LIMITS-1:0] lim_clr;
    logic [NUM_LIMITS-1:0] lim_reached;
    logic [NUM_LIMITS-1:0] lim_hit;
    logic                  msg_bound;
    logic                  any_reached;

    // Purpose: derive count and clear conditions for each budget.
    always_comb begin
        msg_bound = start_det || stop_det;
        lim_inc[IDX_CONT] = enable && !scl_in;
        lim_clr[IDX_CONT] = !enable || scl_in;
        lim_inc[IDX_MEXT] = enable && role_master && stretch_active;
        lim_clr[IDX_MEXT] = !enable || msg_bound;
        lim_inc[IDX_SEXT] = enable && !role_master && stretch_active;
        lim_clr[IDX_SEXT] = !enable || msg_bound;
    end

    // One counter per budget; stretch budgets trip only when exceeded.
    for (genvar gi = 0; gi < NUM_LIMITS; gi++) begin : g_lim
        localparam int unsigned LIM =
            (gi == IDX_CONT) ? TLOW_CYC :
            (gi == IDX_MEXT) ? MEXT_CYC + 1 : SEXT_CYC + 1;
        tlow_sat_counter #(
            .LIMIT (LIM),
            .WIDTH (cnt_width(LIM))
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (lim_clr[gi]),
            .inc      (lim_inc[gi]),
            .reached  (lim_reached[gi]),
            .at_limit (lim_hit[gi])
        );
    end

    // Purpose: merge the per-budget events into one hit.
    always_comb begin
        any_reached = |lim_reached;
    end

    tlow_flag_ctrl u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .role_master (role_master),
        .hit         (any_reached),
        .wr_en       (flag_wr_en),
        .wr_data     (flag_wr_data),
        .flag        (timeout_flag),
        .stop_req    (master_stop_req),
        .reset_req   (slave_reset_req)
    );

endmodule

// File: rtl/tlow_monitor_checker.sv
// Module: assertion checker for smbus_tlow_monitor, attached by bind.
// Assumes: sees the top's ports plus its per-budget counter state.
module tlow_monitor_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       scl_in,
    input logic       role_master,
    input logic       start_det,
    input logic       stop_det,
    input logic       flag_wr_en,
    input logic       flag_wr_data,
    input logic       timeout_flag,
    input logic       slave_reset_req,
    input logic       master_stop_req,
    input logic [2:0] lim_clr,
    input logic [2:0] lim_reached,
    input logic [2:0] lim_hit
);

    assert_rise_needs_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> $past(|lim_reached));

    assert_high_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(scl_in) |-> !lim_hit[0]);

    assert_bound_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start_det) || $past(stop_det)) |-> (lim_hit[2:1] == 2'b00));

    assert_stop_role_R6: assert property (@(posedge clk) disable iff (!rst_n)
        master_stop_req |-> (timeout_flag && $past(role_master)));

    assert_req_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(master_stop_req && slave_reset_req));

    assert_rise_has_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> (master_stop_req || slave_reset_req));

    assert_reset_role_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slave_reset_req |-> (timeout_flag && !$past(role_master)));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && enable && !(flag_wr_en && !flag_wr_data)) |=> timeout_flag);

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!timeout_flag && !master_stop_req && !slave_reset_req
                     && (lim_hit == 3'b000)));

    assert_sat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(lim_hit) & ~$past(lim_clr)) & ~lim_hit) == 3'b000);

    assert_reach_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_reached & $past(lim_reached)) == 3'b000);

endmodule

bind smbus_tlow_monitor tlow_monitor_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .enable          (enable),
    .scl_in          (scl_in),
    .role_master     (role_master),
    .start_det       (start_det),
    .stop_det        (stop_det),
    .flag_wr_en      (flag_wr_en),
    .flag_wr_data    (flag_wr_data),
    .timeout_flag    (timeout_flag),
    .slave_reset_req (slave_reset_req),
    .master_stop_req (master_stop_req),
    .lim_clr         (lim_clr),
    .lim_reached     (lim_reached),
    .lim_hit         (lim_hit)
);

// File: tb/smbus_tlow_monitor_tb.sv
// Bench: sweeps of low-run lengths and stretch splits on a small configuration.
module smbus_tlow_monitor_tb;

    localparam int unsigned T_L = 6;
    localparam int unsigned M_L = 3;
    localparam int unsigned S_L = 5;

    logic clk = 1'b0;
    logic rst_n, enable, scl_in, role_master, stretch_active;
    logic start_det, stop_det, flag_wr_en, flag_wr_data;
    logic timeout_flag, slave_reset_req, master_stop_req;

    always #10 clk = ~clk;

    smbus_tlow_monitor #(.TLOW_CYC(T_L), .MEXT_CYC(M_L), .SEXT_CYC(S_L)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in),
        .role_master(role_master), .stretch_active(stretch_active),
        .start_det(start_det), .stop_det(stop_det),
        .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .timeout_flag(timeout_flag), .slave_reset_req(slave_reset_req),
        .master_stop_req(master_stop_req)
    );

    int unsigned n_vec = 0, n_bad = 0;
    int unsigned n_mreq = 0, n_sreq = 0, n_misalign = 0;
    int unsigned cyc = 0;
    logic prev_flag = 1'b0;

    // Advance one clock; sample outputs at the falling edge.
    task automatic tick();
        @(negedge clk);
        if (master_stop_req) n_mreq++;
        if (slave_reset_req) n_sreq++;
        if (timeout_flag && !prev_flag && !(master_stop_req || slave_reset_req))
            n_misalign++;
        prev_flag = timeout_flag;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        scl_in = 1'b1; stretch_active = 1'b0; start_det = 1'b0;
        stop_det = 1'b0; flag_wr_en = 1'b0; flag_wr_data = 1'b1;
    endtask

    // Clear flag and counts through the enable input, then zero tallies.
    task automatic clean();
        idle();
        enable = 1'b0; tick();
        enable = 1'b1; tick();
        n_mreq = 0; n_sreq = 0; n_misalign = 0;
        prev_flag = timeout_flag;
    endtask

    task automatic check_reqs(input string tag, input bit r, input bit fired);
        check({tag, " stop req count"},  int'(n_mreq), (r && fired) ? 1 : 0);
        check({tag, " reset req count"}, int'(n_sreq), (!r && fired) ? 1 : 0);
        check({tag, " req aligned"},     int'(n_misalign), 0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int lim;
        idle();
        enable = 1'b1; role_master = 1'b0; rst_n = 1'b0;
        ticks(3);
        check("reset flag", int'(timeout_flag), 0);
        check("reset reqs", int'({master_stop_req, slave_reset_req}), 0);
        rst_n = 1'b1;
        tick();

        // R1, R6, R7: single low run of every length around the limit
        for (int r = 0; r < 2; r++) begin
            for (int n = 1; n <= int'(T_L) + 2; n++) begin
                clean();
                role_master = r[0];
                scl_in = 1'b0; ticks(n);
                scl_in = 1'b1; ticks(3);
                check("R1 unbroken low flag", int'(timeout_flag), (n >= int'(T_L)) ? 1 : 0);
                check_reqs(r ? "R6" : "R7", r[0], n >= int'(T_L));
            end
        end

        // R2: two low runs separated by one high sample
        for (int a = 1; a <= int'(T_L); a++) begin
            for (int b = 1; b <= int'(T_L); b++) begin
                clean();
                scl_in = 1'b0; ticks(a);
                scl_in = 1'b1; tick();
                scl_in = 1'b0; ticks(b);
                scl_in = 1'b1; ticks(3);
                check("R2 split low flag", int'(timeout_flag),
                      (a >= int'(T_L) || b >= int'(T_L)) ? 1 : 0);
            end
        end

        // R3, R4: split stretch within one message accumulates
        for (int r = 0; r < 2; r++) begin
            lim = r ? int'(M_L) : int'(S_L);
            for (int k1 = 0; k1 <= lim + 1; k1++) begin
                for (int k2 = 0; k2 <= lim + 1; k2++) begin
                    clean();
                    role_master = r[0];
                    stretch_active = 1'b1; ticks(k1);
                    stretch_active = 1'b0; ticks(2);
                    stretch_active = 1'b1; ticks(k2);
                    stretch_active = 1'b0; ticks(3);
                    check(r ? "R3 master stretch flag" : "R4 slave stretch flag",
                          int'(timeout_flag), (k1 + k2 > lim) ? 1 : 0);
                    check_reqs(r ? "R3" : "R4", r[0], k1 + k2 > lim);
                end
            end
        end

        // R5: START or STOP between stretch periods restarts the total
        for (int r = 0; r < 2; r++) begin
            lim = r ? int'(M_L) : int'(S_L);
            for (int k1 = 0; k1 <= lim + 1; k1++) begin
                for (int k2 = 0; k2 <= lim + 1; k2++) begin
                    clean();
                    role_master = r[0];
                    stretch_active = 1'b1; ticks(k1);
                    stretch_active = 1'b0;
                    if (((k1 + k2) % 2) == 0) start_det = 1'b1; else stop_det = 1'b1;
                    tick();
                    start_det = 1'b0; stop_det = 1'b0; tick();
                    stretch_active = 1'b1; ticks(k2);
                    stretch_active = 1'b0; ticks(3);
                    check("R5 boundary restart flag", int'(timeout_flag),
                          (k1 > lim || k2 > lim) ? 1 : 0);
                end
            end
        end

        // R5: roles keep separate totals
        for (int k1 = 0; k1 <= int'(M_L) + 1; k1++) begin
            for (int k2 = 0; k2 <= int'(S_L) + 1; k2++) begin
                clean();
                role_master = 1'b1;
                stretch_active = 1'b1; ticks(k1);
                stretch_active = 1'b0; role_master = 1'b0; tick();
                stretch_active = 1'b1; ticks(k2);
                stretch_active = 1'b0; ticks(3);
                check("R5 role independence flag", int'(timeout_flag),
                      (k1 > int'(M_L) || k2 > int'(S_L)) ? 1 : 0);
            end
        end

        // R8, R10: write semantics and no re-trigger while saturated
        clean();
        role_master = 1'b1;
        scl_in = 1'b0; ticks(T_L);
        check("R1 flag still clear at limit edge", int'(timeout_flag), 0);
        flag_wr_en = 1'b1; flag_wr_data = 1'b0; tick();
        flag_wr_en = 1'b0;
        check("R8 set wins over clear", int'(timeout_flag), 1);
        flag_wr_en = 1'b1; flag_wr_data = 1'b1; tick();
        flag_wr_en = 1'b0;
        check("R8 write one keeps flag", int'(timeout_flag), 1);
        flag_wr_en = 1'b1; flag_wr_data = 1'b0; tick();
        flag_wr_en = 1'b0; flag_wr_data = 1'b1;
        check("R8 write zero clears flag", int'(timeout_flag), 0);
        ticks(2 * T_L);
        check("R10 saturated no re-set", int'(timeout_flag), 0);
        check("R10 single stop request", int'(n_mreq), 1);
        scl_in = 1'b1; tick();
        scl_in = 1'b0; ticks(T_L + 1);
        check("R2 restart after high re-sets flag", int'(timeout_flag), 1);
        check("R6 second stop request", int'(n_mreq), 2);

        // R9: disable holds everything clear and restarts counts
        clean();
        role_master = 1'b0;
        enable = 1'b0; scl_in = 1'b0; ticks(2 * T_L);
        check("R9 flag held clear", int'(timeout_flag), 0);
        check("R9 no requests", int'(n_mreq + n_sreq), 0);
        enable = 1'b1; ticks(T_L);
        check("R9 count restarted", int'(timeout_flag), 0);
        tick();
        check("R9 flag after full run", int'(timeout_flag), 1);
        enable = 1'b0; tick();
        check("R9 disable clears flag", int'(timeout_flag), 0);
        enable = 1'b1; scl_in = 1'b1; role_master = 1'b1; tick();
        stretch_active = 1'b1; ticks(M_L);
        enable = 1'b0; tick();
        enable = 1'b1; tick();
        stretch_active = 1'b0; ticks(3);
        check("R9 disable clears stretch total", int'(timeout_flag), 0);

        summary();
        $finish;
    end

endmodule